// File: doc/BRIEF.md
# Tag-Based Reservation Station

This block holds renamed instructions that are waiting for their source operands and sends them to a single functional unit in dataflow order. Each insert carries an operation code, a destination tag and two sources. A source is either a ready value or the tag of the instruction that will produce it. A tag is the reorder-buffer entry ID of the producer. A parked instruction keeps watching the result broadcast bus. When a broadcast tag matches a source that is still waiting, the slot captures the value and marks that source ready.

The pool has a fixed number of slots. A slot may issue once both of its sources are ready. When several slots may issue, the one inserted earliest goes first. Younger independent work therefore overtakes older dependent work. Issue uses a valid/ready handshake toward the functional unit. A flush input empties the whole pool, for example on an exception or a mispredict recovery.

Top module: `tag_rs`

## Requirements
- R1: After reset no slot is occupied, `iss_valid_o` is low and `ins_ready_o` is high.
- R2: An insert is taken when `ins_valid_i` and `ins_ready_o` are high and `flush_i` is low. `ins_ready_o` is low exactly when all NUM_SLOTS slots are occupied. An insert offered while `ins_ready_o` is low is dropped.
- R3: `iss_valid_o` is high exactly when at least one occupied slot has both sources ready. A slot inserted in cycle N can be offered no earlier than cycle N+1.
- R4: A broadcast with `bc_valid_i` high whose `bc_tag_i` equals a waiting source's tag writes `bc_val_i` into that source and marks it ready at the same clock edge. That value later appears on `iss_a_o` (source 1) or `iss_b_o` (source 2).
- R5: A broadcast in the same cycle as an accepted insert is captured by the new slot for each source whose ready flag is low and whose tag matches.
- R6: Among the slots that may issue, the issue port presents the one that was inserted first.
- R7: An independent younger instruction issues while an older instruction is still waiting on a tag.
- R8: The issuing slot is freed at the edge where `iss_valid_o` and `iss_ready_i` are both high. While `iss_ready_i` is low and no broadcast or flush arrives, the issue outputs stay unchanged.
- R9: `flush_i` empties every slot at the next edge and overrides an insert in the same cycle.
- R10: A source inserted as ready keeps its value when a broadcast carries a tag equal to its tag field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty all slots |
| ins_valid_i | input | 1 | Insert request |
| ins_ready_o | output | 1 | A free slot exists |
| ins_op_i | input | OP_W | Operation code |
| ins_dst_tag_i | input | TAG_W | Tag of the result this instruction produces |
| ins_a_rdy_i | input | 1 | Source 1 carries a value (1) or a producer tag (0) |
| ins_a_tag_i | input | TAG_W | Source 1 producer tag |
| ins_a_val_i | input | DATA_W | Source 1 value |
| ins_b_rdy_i | input | 1 | Source 2 carries a value (1) or a producer tag (0) |
| ins_b_tag_i | input | TAG_W | Source 2 producer tag |
| ins_b_val_i | input | DATA_W | Source 2 value |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Broadcast producer tag |
| bc_val_i | input | DATA_W | Broadcast value |
| iss_valid_o | output | 1 | An instruction is offered to the functional unit |
| iss_ready_i | input | 1 | Functional unit accepts |
| iss_op_o | output | OP_W | Offered operation code |
| iss_a_o | output | DATA_W | Offered source 1 value |
| iss_b_o | output | DATA_W | Offered source 2 value |
| iss_dst_tag_o | output | TAG_W | Offered destination tag |

## Verification
The bench builds the block with four slots, 4-bit tags and 16-bit data. It draws tags from only eight values, so broadcasts often hit waiting sources, and occasionally hit several sources or an insert in the same cycle. With four slots the full-pool stall and wrap-around reuse of freed slots occur many times, so the age ordering is tested across slot reallocation. A random back-pressure pattern on `iss_ready_i` lets several slots become eligible together, which exercises oldest-first selection.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/rs_src.sv
module rs_src #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              occ_i,
  input  logic              load_i,
  input  logic              load_rdy_i,
  input  logic [TAG_W-1:0]  load_tag_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] val_o
);
  logic              rdy_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              hit_new, hit_old;

  // capture on the insert cycle as well as while parked
  assign hit_new = !load_rdy_i && bc_valid_i && (bc_tag_i == load_tag_i);
  assign hit_old = occ_i && !rdy_q && bc_valid_i && (bc_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      tag_q <= '0;
      val_q <= '0;
    end else if (load_i) begin
      tag_q <= load_tag_i;
      rdy_q <= load_rdy_i | hit_new;
      val_q <= hit_new ? bc_val_i : load_val_i;
    end else if (hit_old) begin
      rdy_q <= 1'b1;
      val_q <= bc_val_i;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           alloc_i,
  input  logic                           free_i,
  input  logic [OP_W-1:0]                ins_op_i,
  input  logic [TAG_W-1:0]               ins_dst_i,
  input  logic [NUM_SRC-1:0]             ins_rdy_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]  ins_tag_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] ins_val_i,
  input  logic                           bc_valid_i,
  input  logic [TAG_W-1:0]               bc_tag_i,
  input  logic [DATA_W-1:0]              bc_val_i,
  output logic                           occ_o,
  output logic                           elig_o,
  output logic [OP_W-1:0]                op_o,
  output logic [TAG_W-1:0]               dst_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0] val_o
);
  logic              occ_q;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  dst_q;
  logic [NUM_SRC-1:0] rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= 1'b0;
      op_q  <= '0;
      dst_q <= '0;
    end else begin
      if (flush_i)      occ_q <= 1'b0;
      else if (alloc_i) occ_q <= 1'b1;
      else if (free_i)  occ_q <= 1'b0;
      if (alloc_i) begin
        op_q  <= ins_op_i;
        dst_q <= ins_dst_i;
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rs_src #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .occ_i      (occ_q),
      .load_i     (alloc_i),
      .load_rdy_i (ins_rdy_i[s]),
      .load_tag_i (ins_tag_i[s]),
      .load_val_i (ins_val_i[s]),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_val_i   (bc_val_i),
      .rdy_o      (rdy[s]),
      .val_o      (val_o[s])
    );
  end

  assign occ_o  = occ_q;
  assign elig_o = occ_q && (&rdy);
  assign op_o   = op_q;
  assign dst_o  = dst_q;
endmodule

// File: rtl/rs_age.sv
module rs_age #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] alloc_i,
  input  logic [NUM_SLOTS-1:0] elig_i,
  output logic [NUM_SLOTS-1:0] grant_o
);
  // older_q[j][i] set: slot j entered before slot i
  logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < NUM_SLOTS; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pick
    logic [NUM_SLOTS-1:0] blocker;
    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_cmp
      assign blocker[j] = elig_i[j] && older_q[j][i];
    end
    assign grant_o[i] = elig_i[i] && !(|blocker);
  end
endmodule

// File: rtl/tag_rs.sv
module tag_rs
  import rs_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 32,
  parameter int OP_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ins_valid_i,
  output logic              ins_ready_o,
  input  logic [OP_W-1:0]   ins_op_i,
  input  logic [TAG_W-1:0]  ins_dst_tag_i,
  input  logic              ins_a_rdy_i,
  input  logic [TAG_W-1:0]  ins_a_tag_i,
  input  logic [DATA_W-1:0] ins_a_val_i,
  input  logic              ins_b_rdy_i,
  input  logic [TAG_W-1:0]  ins_b_tag_i,
  input  logic [DATA_W-1:0] ins_b_val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              iss_valid_o,
  input  logic              iss_ready_i,
  output logic [OP_W-1:0]   iss_op_o,
  output logic [DATA_W-1:0] iss_a_o,
  output logic [DATA_W-1:0] iss_b_o,
  output logic [TAG_W-1:0]  iss_dst_tag_o
);
  logic [NUM_SLOTS-1:0] occ, elig, grant, free, alloc;
  logic [NUM_SLOTS-1:0][OP_W-1:0]                slot_op;
  logic [NUM_SLOTS-1:0][TAG_W-1:0]               slot_dst;
  logic [NUM_SLOTS-1:0][NUM_SRC-1:0][DATA_W-1:0] slot_val;
  logic [NUM_SRC-1:0]             in_rdy;
  logic [NUM_SRC-1:0][TAG_W-1:0]  in_tag;
  logic [NUM_SRC-1:0][DATA_W-1:0] in_val;
  logic ins_fire, iss_fire;

  assign in_rdy = {ins_b_rdy_i, ins_a_rdy_i};
  assign in_tag = {ins_b_tag_i, ins_a_tag_i};
  assign in_val = {ins_b_val_i, ins_a_val_i};

  assign free        = ~occ;
  assign ins_ready_o = |free;
  assign ins_fire    = ins_valid_i && ins_ready_o && !flush_i;
  // lowest free slot, one-hot
  assign alloc       = ins_fire ? (free & (~free + 1'b1)) : '0;
  assign iss_valid_o = |elig;
  assign iss_fire    = iss_valid_o && iss_ready_i;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .alloc_i    (alloc[i]),
      .free_i     (grant[i] && iss_fire),
      .ins_op_i   (ins_op_i),
      .ins_dst_i  (ins_dst_tag_i),
      .ins_rdy_i  (in_rdy),
      .ins_tag_i  (in_tag),
      .ins_val_i  (in_val),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_val_i   (bc_val_i),
      .occ_o      (occ[i]),
      .elig_o     (elig[i]),
      .op_o       (slot_op[i]),
      .dst_o      (slot_dst[i]),
      .val_o      (slot_val[i])
    );
  end

  rs_age #(.NUM_SLOTS(NUM_SLOTS)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc),
    .elig_i  (elig),
    .grant_o (grant)
  );

  always_comb begin
    iss_op_o      = '0;
    iss_dst_tag_o = '0;
    iss_a_o       = '0;
    iss_b_o       = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (grant[i]) begin
        iss_op_o      |= slot_op[i];
        iss_dst_tag_o |= slot_dst[i];
        iss_a_o       |= slot_val[i][0];
        iss_b_o       |= slot_val[i][1];
      end
    end
  end
endmodule

// File: rtl/tag_rs_checker.sv
module tag_rs_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 32,
  parameter int OP_W      = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 flush_i,
  input logic                 ins_valid_i,
  input logic                 ins_ready_o,
  input logic                 bc_valid_i,
  input logic                 iss_valid_o,
  input logic                 iss_ready_i,
  input logic [OP_W-1:0]      iss_op_o,
  input logic [DATA_W-1:0]    iss_a_o,
  input logic [DATA_W-1:0]    iss_b_o,
  input logic [TAG_W-1:0]     iss_dst_tag_o,
  input logic [NUM_SLOTS-1:0] grant_i
);
  localparam int CW = $clog2(NUM_SLOTS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else cnt_q <= cnt_q + CW'(ins_valid_i && ins_ready_o) - CW'(iss_valid_o && iss_ready_i);
  end

  // R2: stall exactly when the pool is full
  a_r2_ready_vs_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_ready_o == (cnt_q < CW'(NUM_SLOTS)));

  // R3: nothing offered from an empty pool
  a_r3_empty_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !iss_valid_o);

  // R6: at most one slot selected
  a_r6_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  // R8: offer holds under back-pressure
  a_r8_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_ready_i && !bc_valid_i && !flush_i) |=>
      (iss_valid_o && $stable(iss_op_o) && $stable(iss_a_o) && $stable(iss_b_o)
       && $stable(iss_dst_tag_o)));

  // R9: flush empties the pool
  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!iss_valid_o && ins_ready_o));
endmodule

bind tag_rs tag_rs_checker #(
  .NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .ins_valid_i   (ins_valid_i),
  .ins_ready_o   (ins_ready_o),
  .bc_valid_i    (bc_valid_i),
  .iss_valid_o   (iss_valid_o),
  .iss_ready_i   (iss_ready_i),
  .iss_op_o      (iss_op_o),
  .iss_a_o       (iss_a_o),
  .iss_b_o       (iss_b_o),
  .iss_dst_tag_o (iss_dst_tag_o),
  .grant_i       (grant)
);

// File: tb/tag_rs_bench.sv
module tag_rs_bench;
  localparam int N = 4, TW = 4, DW = 16, OW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic flush_i = 0, ins_valid_i = 0, ins_a_rdy_i = 0, ins_b_rdy_i = 0;
  logic [OW-1:0] ins_op_i = '0;
  logic [TW-1:0] ins_dst_tag_i = '0, ins_a_tag_i = '0, ins_b_tag_i = '0, bc_tag_i = '0;
  logic [DW-1:0] ins_a_val_i = '0, ins_b_val_i = '0, bc_val_i = '0;
  logic bc_valid_i = 0, iss_ready_i = 0;
  logic ins_ready_o, iss_valid_o;
  logic [OW-1:0] iss_op_o;
  logic [DW-1:0] iss_a_o, iss_b_o;
  logic [TW-1:0] iss_dst_tag_o;

  always #5 clk_i = ~clk_i;

  tag_rs #(.NUM_SLOTS(N), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) u_tag_rs (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference pool
  bit          m_occ[N];
  int          m_seq[N];
  logic [OW-1:0] m_op[N];
  logic [TW-1:0] m_dst[N];
  bit          m_r[N][2];
  logic [TW-1:0] m_t[N][2];
  logic [DW-1:0] m_v[N][2];
  int seq_ctr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int oldest_ready();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_occ[i] && m_r[i][0] && m_r[i][1] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
    return best;
  endfunction

  // compare outputs, advance the model with the current inputs, step one clock
  task automatic step();
    int b, cnt, fs;
    b = oldest_ready();
    cnt = 0; fs = -1;
    for (int i = 0; i < N; i++) if (m_occ[i]) cnt++; else if (fs < 0) fs = i;
    chk(iss_valid_o == (b >= 0), "R3 iss_valid", 32'(iss_valid_o), 32'(b >= 0));
    chk(ins_ready_o == (cnt < N), "R2 ins_ready", 32'(ins_ready_o), 32'(cnt < N));
    if (b >= 0) begin
      chk(iss_dst_tag_o == m_dst[b], "R6 dst", 32'(iss_dst_tag_o), 32'(m_dst[b]));
      chk(iss_op_o == m_op[b], "R6 op", 32'(iss_op_o), 32'(m_op[b]));
      chk(iss_a_o == m_v[b][0], "R4 a", 32'(iss_a_o), 32'(m_v[b][0]));
      chk(iss_b_o == m_v[b][1], "R4 b", 32'(iss_b_o), 32'(m_v[b][1]));
    end
    if (flush_i) begin
      for (int i = 0; i < N; i++) m_occ[i] = 0;
    end else begin
      if (b >= 0 && iss_ready_i) m_occ[b] = 0;
      for (int i = 0; i < N; i++)
        for (int s = 0; s < 2; s++)
          if (m_occ[i] && !m_r[i][s] && bc_valid_i && bc_tag_i == m_t[i][s]) begin
            m_r[i][s] = 1; m_v[i][s] = bc_val_i;
          end
      if (ins_valid_i && fs >= 0) begin
        m_occ[fs] = 1; m_seq[fs] = seq_ctr++; m_op[fs] = ins_op_i; m_dst[fs] = ins_dst_tag_i;
        m_r[fs][0] = ins_a_rdy_i; m_t[fs][0] = ins_a_tag_i; m_v[fs][0] = ins_a_val_i;
        m_r[fs][1] = ins_b_rdy_i; m_t[fs][1] = ins_b_tag_i; m_v[fs][1] = ins_b_val_i;
        for (int s = 0; s < 2; s++)
          if (!m_r[fs][s] && bc_valid_i && bc_tag_i == m_t[fs][s]) begin
            m_r[fs][s] = 1; m_v[fs][s] = bc_val_i;
          end
      end
    end
    @(negedge clk_i);
  endtask

  task automatic idle();
    ins_valid_i = 0; bc_valid_i = 0; flush_i = 0; iss_ready_i = 0;
  endtask

  task automatic ins(input logic [OW-1:0] op, input logic [TW-1:0] dst,
                     input bit ar, input logic [TW-1:0] at, input logic [DW-1:0] av,
                     input bit br, input logic [TW-1:0] bt, input logic [DW-1:0] bv);
    ins_valid_i = 1; ins_op_i = op; ins_dst_tag_i = dst;
    ins_a_rdy_i = ar; ins_a_tag_i = at; ins_a_val_i = av;
    ins_b_rdy_i = br; ins_b_tag_i = bt; ins_b_val_i = bv;
  endtask

  task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
    bc_valid_i = 1; bc_tag_i = t; bc_val_i = v;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: reset state
    chk(iss_valid_o == 0, "R1 iss_valid", 32'(iss_valid_o), 0);
    chk(ins_ready_o == 1, "R1 ins_ready", 32'(ins_ready_o), 1);

    // R7: older waits on tag 3, younger independent one goes first
    idle(); ins(4'h1, 4'h1, 1, 4'h0, 16'h0005, 0, 4'h3, 16'h0); step();
    idle(); ins(4'h2, 4'h2, 1, 4'h0, 16'h0007, 1, 4'h0, 16'h0008); step();
    idle(); step();
    chk(iss_valid_o && iss_dst_tag_o == 4'h2, "R7 younger issues", 32'(iss_dst_tag_o), 32'h2);
    idle(); step();
    chk(iss_dst_tag_o == 4'h2 && iss_a_o == 16'h7, "R8 hold", 32'(iss_a_o), 32'h7);
    // R4: wake-up by broadcast, then R6 oldest first
    idle(); bcast(4'h3, 16'h0009); step();
    chk(iss_dst_tag_o == 4'h1, "R6 oldest", 32'(iss_dst_tag_o), 32'h1);
    chk(iss_b_o == 16'h9 && iss_a_o == 16'h5, "R4 captured", 32'(iss_b_o), 32'h9);
    idle(); iss_ready_i = 1; step();
    chk(iss_dst_tag_o == 4'h2, "R8 freed", 32'(iss_dst_tag_o), 32'h2);
    idle(); iss_ready_i = 1; step();
    chk(iss_valid_o == 0, "R8 empty", 32'(iss_valid_o), 0);

    // R5: broadcast in the insert cycle
    idle(); ins(4'h3, 4'h4, 0, 4'h6, 16'h0, 1, 4'h0, 16'h0004); bcast(4'h6, 16'h0033); step();
    chk(iss_valid_o && iss_a_o == 16'h33, "R5 same-cycle capture", 32'(iss_a_o), 32'h33);
    // R10: ready source not overwritten by a matching tag
    idle(); ins(4'h4, 4'h5, 1, 4'h5, 16'h0011, 0, 4'h7, 16'h0); step();
    idle(); bcast(4'h5, 16'h0099); step();
    idle(); bcast(4'h7, 16'h0022); iss_ready_i = 1; step();
    chk(iss_valid_o && iss_dst_tag_o == 4'h5, "R6 next", 32'(iss_dst_tag_o), 32'h5);
    chk(iss_a_o == 16'h11 && iss_b_o == 16'h22, "R10 kept value", 32'(iss_a_o), 32'h11);
    idle(); iss_ready_i = 1; step();

    // R2: fill, then offer a fifth
    for (int k = 0; k < N; k++) begin
      idle(); ins(4'h5, 4'(8 + k), 0, 4'h9, 16'h0, 1, 4'h0, 16'h1); step();
    end
    chk(ins_ready_o == 0, "R2 full stall", 32'(ins_ready_o), 0);
    idle(); ins(4'h6, 4'hF, 1, 4'h0, 16'h1, 1, 4'h0, 16'h2); step();
    chk(iss_valid_o == 0, "R2 dropped when full", 32'(iss_valid_o), 0);
    // R9: flush beats a concurrent insert
    idle(); flush_i = 1; step();
    chk(ins_ready_o == 1 && iss_valid_o == 0, "R9 flushed", 32'(ins_ready_o), 1);
    idle(); flush_i = 1; ins(4'h7, 4'hE, 1, 4'h0, 16'h1, 1, 4'h0, 16'h2); step();
    idle(); step();
    chk(iss_valid_o == 0, "R9 insert dropped", 32'(iss_valid_o), 0);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      ins_valid_i = ($urandom % 2) == 0;
      ins(4'($urandom), 4'($urandom), ($urandom % 2) == 0, 4'($urandom % 8), 16'($urandom),
          ($urandom % 2) == 0, 4'($urandom % 8), 16'($urandom));
      ins_valid_i = ($urandom % 2) == 0;
      bc_valid_i  = ($urandom % 5) < 2;
      bc_tag_i    = 4'($urandom % 8);
      bc_val_i    = 16'($urandom);
      iss_ready_i = ($urandom % 5) < 3;
      flush_i     = ($urandom % 100) == 0;
      step();
    end
    idle(); step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule